// File: doc/BRIEF.md
# Multi-Mode 16-bit Sequential Divider

This block divides a 16-bit dividend by a 16-bit divisor in one of three modes: unsigned integer, signed integer, or unsigned fractional. In fractional mode the dividend is read as a fraction of the divisor, and the block returns the 16-bit quotient of (dividend × 65536) / divisor. All three modes share one restoring shift-subtract datapath. Signed operands are turned into magnitudes on entry, and the signs are put back when the result is written.

A caller pulses `start` with the operands and the mode. The block then stays busy for a fixed twelve clock edges, pulses `done` for one cycle, and presents the quotient as the primary result, the remainder, and the N, Z, V and C condition flags. Divide by zero and quotient overflow give fixed, documented results. Results and flags hold until the next operation completes.

Top module: `div16_unit`

## Requirements
- R1: A start sampled high at a clock edge while `busy` is low raises `busy` from that edge. Exactly 12 edges later, `busy` falls and `done` rises.
- R2: In mode 0 (unsigned integer), `quotient` = dividend / divisor and `remainder` = dividend mod divisor, both unsigned.
- R3: In unsigned integer mode, Z is set when the quotient is zero. V is cleared, C is cleared for a nonzero divisor, and N keeps its previous value.
- R4: In mode 1 (signed integer), the quotient is truncated toward zero and the remainder takes the sign of the dividend.
- R5: In signed mode, N is quotient bit 15 and Z marks a zero quotient. V is set only for -32768 / -1, which returns quotient 0x8000 and remainder 0. C is cleared for a nonzero divisor.
- R6: In mode 2 (fractional), when the divisor is greater than the dividend, `quotient` = floor(dividend·65536 / divisor) and `remainder` = (dividend·65536) mod divisor. Z marks a zero quotient, V and C are cleared, and N is kept.
- R7: In fractional mode with a nonzero divisor that is less than or equal to the dividend, V is set, C is cleared, Z is cleared, N is kept, `quotient` = 0xFFFF and `remainder` = dividend.
- R8: A zero divisor in any mode gives C = 1, Z = 0, `quotient` = 0xFFFF and `remainder` = dividend. V is 1 in fractional mode and 0 otherwise. N is 1 in signed mode and is kept otherwise.
- R9: A start while `busy` is high is ignored. The operation in flight completes with its own operands and its own timing.
- R10: `done` is high for exactly one cycle. Quotient, remainder and flags change only in the cycle where `done` rises.
- R11: Mode 3 behaves exactly as unsigned integer mode.
- R12: After reset, `busy`, `done`, `quotient`, `remainder` and all four flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| mode | input | 2 | 0 unsigned, 1 signed, 2 fractional, 3 unsigned |
| dividend | input | 16 | Dividend, sampled with start |
| divisor | input | 16 | Divisor, sampled with start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Quotient (primary result) |
| remainder | output | 16 | Remainder |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Divide-by-zero flag |

## Verification
The completion pulse of one operation and the acceptance of the next can fall in the same cycle, because `busy` is already low while `done` is high. The bench provokes this by raising `start` in the very cycle its model predicts `done`. It then checks that the second operation's results arrive exactly 12 edges later and that the first result is held until then. A second case drives `start` in the last busy cycle, one edge too early: that start must be ignored, and the bench judges this by comparing busy, done, results and flags against the model on every clock.

// File: rtl/div16_unit.sv
module div16_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  mode,
  input  logic [15:0] dividend,
  input  logic [15:0] divisor,
  output logic        busy,
  output logic        done,
  output logic [15:0] quotient,
  output logic [15:0] remainder,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_v,
  output logic        flag_c
);
  localparam logic [1:0] M_SGN = 2'd1;
  localparam logic [1:0] M_FRC = 2'd2;
  localparam logic [3:0] LAST  = 4'd11;
  localparam logic [3:0] NSTEP = 4'd8;

  logic [3:0]  cnt;
  logic [1:0]  md;
  logic        neg_q, neg_r, zero_d, frc_ovf;
  logic [15:0] dvs, pr, acc, a_org;

  function automatic logic [31:0] dstep(input logic [31:0] s, input logic [15:0] d);
    logic [16:0] t, diff;
    t    = {s[31:16], s[15]};
    diff = t - {1'b0, d};
    if (t >= {1'b0, d}) return {diff[15:0], s[14:0], 1'b1};
    else                return {t[15:0], s[14:0], 1'b0};
  endfunction

  wire        sgn   = (mode == M_SGN);
  wire        frc   = (mode == M_FRC);
  wire [15:0] a_mag = (sgn && dividend[15]) ? -dividend : dividend;
  wire [15:0] b_mag = (sgn && divisor[15])  ? -divisor  : divisor;

  wire [31:0] s1 = dstep({pr, acc}, dvs);
  wire [31:0] s2 = dstep(s1, dvs);

  wire        spec  = zero_d | frc_ovf;
  wire [15:0] q_sg  = neg_q ? -acc : acc;
  wire [15:0] r_sg  = neg_r ? -pr  : pr;
  wire [15:0] q_fin = spec ? 16'hFFFF : q_sg;
  wire [15:0] r_fin = spec ? a_org    : r_sg;
  wire        s_ovf = (md == M_SGN) && !zero_d && (a_org == 16'h8000) && (dvs == 16'd1) && !neg_q;
  wire        v_fin = (md == M_FRC) ? frc_ovf : s_ovf;
  wire        n_fin = (md == M_SGN) ? q_fin[15] : flag_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; cnt <= '0; md <= '0;
      neg_q <= 1'b0; neg_r <= 1'b0; zero_d <= 1'b0; frc_ovf <= 1'b0;
      dvs <= '0; pr <= '0; acc <= '0; a_org <= '0;
      quotient <= '0; remainder <= '0;
      flag_n <= 1'b0; flag_z <= 1'b0; flag_v <= 1'b0; flag_c <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          cnt     <= '0;
          md      <= mode;
          a_org   <= dividend;
          dvs     <= b_mag;
          neg_q   <= sgn && (dividend[15] ^ divisor[15]);
          neg_r   <= sgn && dividend[15];
          zero_d  <= (divisor == 16'd0);
          frc_ovf <= frc && (divisor <= dividend);
          pr      <= frc ? dividend : 16'd0;
          acc     <= frc ? 16'd0 : a_mag;
        end
      end else begin
        cnt <= cnt + 4'd1;
        if (cnt < NSTEP) {pr, acc} <= s2;
        if (cnt == LAST) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          quotient  <= q_fin;
          remainder <= r_fin;
          flag_n    <= n_fin;
          flag_z    <= (q_fin == 16'd0);
          flag_v    <= v_fin;
          flag_c    <= zero_d;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R1
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(flag_z) && $stable(flag_c))); // R10
  AST_UNS_NO_V: assert property (@(posedge clk) disable iff (!rst_n)
    (done && md != M_SGN && md != M_FRC) |-> !flag_v); // R3
  AST_DIV0_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_c) |-> (quotient == 16'hFFFF && remainder == a_org && !flag_z)); // R8
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != LAST) |=> busy); // R9
endmodule

// File: tb/div16_unit_bench.sv
`timescale 1ns/1ps
module div16_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [15:0] dividend = '0, divisor = '0;
  logic busy, done, flag_n, flag_z, flag_v, flag_c;
  logic [15:0] quotient, remainder;

  always #10 clk = ~clk;

  div16_unit u_div16_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c));

  int checks = 0, fails = 0;
  bit m_busy = 0, m_done = 0;
  int m_cnt = 0;
  logic [15:0] m_q = '0, m_r = '0, p_q, p_r;
  bit m_n = 0, m_z = 0, m_v = 0, m_c = 0, p_n, p_z, p_v, p_c;
  string t_val = "R12", t_flg = "R12", p_tv, p_tf;

  task automatic predict(input logic [1:0] md, input logic [15:0] a, input logic [15:0] b);
    int ia, ib, iq, ir;
    longint num;
    p_n = m_n; p_v = 0; p_c = 0;
    if (b == 16'd0) begin
      p_q = 16'hFFFF; p_r = a; p_c = 1; p_v = (md == 2'd2);
      if (md == 2'd1) p_n = 1;
      p_tv = "R8"; p_tf = "R8";
    end else if (md == 2'd1) begin
      ia = $signed(a); ib = $signed(b);
      iq = ia / ib; ir = ia % ib;
      p_q = iq[15:0]; p_r = ir[15:0]; p_n = p_q[15];
      p_v = (a == 16'h8000 && b == 16'hFFFF);
      p_tv = "R4"; p_tf = "R5";
    end else if (md == 2'd2) begin
      if (b <= a) begin
        p_q = 16'hFFFF; p_r = a; p_v = 1; p_tv = "R7"; p_tf = "R7";
      end else begin
        num = longint'(a) << 16;
        p_q = 16'(num / longint'(b)); p_r = 16'(num % longint'(b));
        p_tv = "R6"; p_tf = "R6";
      end
    end else begin
      p_q = a / b; p_r = a % b;
      p_tv = (md == 2'd3) ? "R11" : "R2";
      p_tf = (md == 2'd3) ? "R11" : "R3";
    end
    p_z = (p_q == 16'd0);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_q = '0; m_r = '0;
      m_n = 0; m_z = 0; m_v = 0; m_c = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          m_q = p_q; m_r = p_r; m_n = p_n; m_z = p_z; m_v = p_v; m_c = p_c;
          t_val = p_tv; t_flg = p_tf;
        end
      end else if (start) begin
        predict(mode, dividend, divisor);
        m_busy = 1; m_cnt = 12;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    string tv, tf;
    tv = !rst_n ? "R12" : (m_done ? t_val : "R10");
    tf = !rst_n ? "R12" : (m_done ? t_flg : "R10");
    check(busy == m_busy, !rst_n ? "R12" : "R1 R9", "busy", busy, m_busy);
    check(done == m_done, !rst_n ? "R12" : "R1 R10", "done", done, m_done);
    check(quotient == m_q, tv, "quotient", quotient, m_q);
    check(remainder == m_r, tv, "remainder", remainder, m_r);
    check({flag_n, flag_z, flag_v, flag_c} == {m_n, m_z, m_v, m_c}, tf, "flags NZVC",
          {flag_n, flag_z, flag_v, flag_c}, {m_n, m_z, m_v, m_c});
  end

  task automatic launch(input logic [1:0] md, input logic [15:0] a, input logic [15:0] b);
    mode = md; dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; dividend = ~a; divisor = ~b; mode = ~md;
  endtask

  task automatic wait_done();
    while (!m_done) @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] md, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    launch(md, a, b);
    wait_done();
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4 R5: signed truncation and N set, then R3: N kept by unsigned
    run_op(2'd1, 16'hFFF9, 16'd2);
    run_op(2'd0, 16'd1000, 16'd7);
    run_op(2'd1, 16'd7, 16'hFFFE);
    run_op(2'd0, 16'd0, 16'd5);
    run_op(2'd0, 16'hFFFF, 16'd1);
    run_op(2'd0, 16'd3, 16'hFFFF);
    run_op(2'd0, 16'd5, 16'd0);        // R8 unsigned
    run_op(2'd1, 16'h8000, 16'hFFFF);  // R5 overflow
    run_op(2'd1, 16'h8000, 16'd1);
    run_op(2'd1, 16'hFF9C, 16'd0);     // R8 signed
    run_op(2'd2, 16'd1, 16'd2);        // R6
    run_op(2'd2, 16'h1234, 16'h5678);
    run_op(2'd2, 16'd0, 16'd3);
    run_op(2'd2, 16'd5, 16'd5);        // R7
    run_op(2'd2, 16'h9000, 16'h0010);  // R7
    run_op(2'd2, 16'd0, 16'd0);        // R8 fractional
    run_op(2'd3, 16'd100, 16'd9);      // R11
    // R9: start mid-operation ignored
    @(negedge clk);
    launch(2'd0, 16'd500, 16'd3);
    repeat (4) @(negedge clk);
    mode = 2'd1; dividend = 16'hFFFF; divisor = 16'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    // R9: start in last busy cycle ignored
    @(negedge clk);
    launch(2'd1, 16'hF000, 16'd3);
    repeat (11) @(negedge clk);
    mode = 2'd0; dividend = 16'd9; divisor = 16'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    // R1 R10: next start issued in the done cycle
    @(negedge clk);
    launch(2'd2, 16'd3, 16'd4);
    wait_done();
    launch(2'd1, 16'h0064, 16'hFFF9);
    wait_done();
    launch(2'd0, 16'd12345, 16'd123);
    wait_done();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule